// File: doc/BRIEF.md
# Edge-Filtered Pin Interrupt Controller

This block watches a small port of input pins and turns qualified level changes into per-pin sticky flags, which are merged into one shared interrupt request. Each pin is first brought into the bus-clock domain by a short synchronizer chain. It then passes through a glitch filter that only accepts a new level after that level has persisted for a set number of bus clocks. Pin levels are observed the same way whether the pad is being driven as an output or read as an input.

Software programs an enable mask and a polarity mask. A polarity bit of 1 selects low-to-high changes and a bit of 0 selects high-to-low changes. Flags are cleared by writing ones to a clear strobe. The request line is high while any flag is set on an enabled pin. A wakeup output repeats that request while the core reports that it is in a low-power mode.

Each pin's filter is a two-state machine:
- `FLT_STEADY`: the synchronized level equals the accepted level. On a mismatch it loads the run counter with 1 and goes to `FLT_COUNT`.
- `FLT_COUNT`: counts consecutive mismatching cycles.
  - If the levels match again, the run is abandoned and the state returns to `FLT_STEADY`.
  - When the run reaches the filter length, the accepted level flips, a one-cycle change pulse is emitted, and the state returns to `FLT_STEADY`.

Top module: `pin_event_ctrl`

## Requirements
- R1: Reset clears the flag, enable and polarity registers. The request and wakeup outputs are low out of reset. Enable and polarity writes replace the whole mask, and the masks read back on `en_o` and `pol_o`.
- R2: `irq_o` is high exactly when some bit is set in both `flags_o` and `en_o`; all pins share this one line.
- R3: A pin level that differs from the accepted level for 3 bus clocks or fewer and then returns never sets a flag.
- R4: A pin level held for 4 bus clocks or more is accepted, and a matching change sets that pin's flag. The pin's flag bit is the bit of `flags_o` with the same index as the pin.
- R5: With polarity bit 1, an accepted low-to-high change sets the flag. With polarity bit 0, an accepted high-to-low change sets it. Changes of the other direction are ignored.
- R6: A clear write with bit value 1 clears that flag. A bit value of 0 leaves the flag unchanged, and flags never set without a qualified change.
- R7: When a qualified change and a clear of the same flag happen in the same cycle, the flag ends up set.
- R8: Flags are set even when the pin's enable bit is 0. Such a flag does not raise `irq_o`.
- R9: Changing the polarity mask while pin levels are stable sets no flag.
- R10: `wake_o` follows `irq_o` while `lowpwr_i` is high and stays low while `lowpwr_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw pin levels |
| lowpwr_i | input | 1 | Core is in a low-power mode |
| en_wr_i | input | 1 | Write strobe for the enable mask |
| en_data_i | input | NPINS | New enable mask |
| pol_wr_i | input | 1 | Write strobe for the polarity mask |
| pol_data_i | input | NPINS | New polarity mask, 1 = rising |
| clr_wr_i | input | 1 | Write strobe for flag clearing |
| clr_data_i | input | NPINS | Ones clear the matching flags |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wakeup request during low power |
| flags_o | output | NPINS | Sticky event flags |
| en_o | output | NPINS | Enable mask |
| pol_o | output | NPINS | Polarity mask |

## Verification
The bench builds the block with its defaults: eight pins, a filter length of four, and two synchronizer stages. With these values, pulses of two and three cycles can be placed directly against pulses of four, five and six cycles, so both sides of the acceptance boundary are exercised on real pins. Because the latency from a pin change to its flag is fixed at seven clock edges, the bench can place a clear write exactly in the cycle a flag is being set. Long pulses produce two accepted changes, so those cases show a flag arising from the trailing edge under either polarity.

// File: rtl/pin_evt_pkg.sv
`timescale 1ns/1ps
package pin_evt_pkg;
    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_COUNT  = 1'b1
    } flt_state_t;
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pin_glitch_filter.sv
`timescale 1ns/1ps
module pin_glitch_filter
    import pin_evt_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic filt,
    output logic toggled
);
    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    flt_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          filt_q, tog_q, flip, diff;

    assign diff = (lvl != filt_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        flip    = 1'b0;
        unique case (state_q)
            FLT_STEADY: begin
                if (diff) begin
                    cnt_d   = CW'(1);
                    state_d = FLT_COUNT;
                end
            end
            FLT_COUNT: begin
                if (!diff) begin
                    cnt_d   = '0;
                    state_d = FLT_STEADY;
                end else if (cnt_q == LAST) begin
                    flip    = 1'b1;
                    cnt_d   = '0;
                    state_d = FLT_STEADY;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = FLT_STEADY;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            filt_q <= filt_q ^ flip;
            tog_q  <= flip;
        end
    end

    assign filt    = filt_q;
    assign toggled = tog_q;

    // R3: accepted level only moves after a mismatch run seen in counting state
    a_r3_flip_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(state_q) == FLT_COUNT && $past(lvl) != $past(filt_q)));

    // R4: change pulse lasts a single cycle
    a_r4_toggle_single: assert property (@(posedge clk) disable iff (!rst_n)
        tog_q |=> !tog_q);
endmodule

// File: rtl/pin_evt_regs.sv
`timescale 1ns/1ps
module pin_evt_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] filt,
    input  logic [NPINS-1:0] toggled,
    input  logic             en_wr,
    input  logic [NPINS-1:0] en_data,
    input  logic             pol_wr,
    input  logic [NPINS-1:0] pol_data,
    input  logic             clr_wr,
    input  logic [NPINS-1:0] clr_data,
    output logic [NPINS-1:0] flags,
    output logic [NPINS-1:0] en,
    output logic [NPINS-1:0] pol,
    output logic             irq
);
    logic [NPINS-1:0] flags_q, en_q, pol_q, set_vec, clr_vec;

    for (genvar i = 0; i < NPINS; i++) begin : g_match
        assign set_vec[i] = toggled[i] & (filt[i] == pol_q[i]);
    end

    assign clr_vec = clr_wr ? clr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            en_q    <= '0;
            pol_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (en_wr)  en_q  <= en_data;
            if (pol_wr) pol_q <= pol_data;
        end
    end

    assign flags = flags_q;
    assign en    = en_q;
    assign pol   = pol_q;
    assign irq   = |(flags_q & en_q);

    // R7: a qualified change always lands, even against a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

    // R6: no flag appears without a qualified change
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

    // R6: without a clear strobe, set flags stay set
    a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/pin_event_ctrl.sv
`timescale 1ns/1ps
module pin_event_ctrl #(
    parameter int NPINS       = 8,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic             lowpwr_i,
    input  logic             en_wr_i,
    input  logic [NPINS-1:0] en_data_i,
    input  logic             pol_wr_i,
    input  logic [NPINS-1:0] pol_data_i,
    input  logic             clr_wr_i,
    input  logic [NPINS-1:0] clr_data_i,
    output logic             irq_o,
    output logic             wake_o,
    output logic [NPINS-1:0] flags_o,
    output logic [NPINS-1:0] en_o,
    output logic [NPINS-1:0] pol_o
);
    logic [NPINS-1:0] sync_lvl, filt_lvl, filt_tog;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst_n (rst_n),
            .d (pin_i[i]),
            .q (sync_lvl[i])
        );
        pin_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (sync_lvl[i]),
            .filt    (filt_lvl[i]),
            .toggled (filt_tog[i])
        );
    end

    pin_evt_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt     (filt_lvl),
        .toggled  (filt_tog),
        .en_wr    (en_wr_i),
        .en_data  (en_data_i),
        .pol_wr   (pol_wr_i),
        .pol_data (pol_data_i),
        .clr_wr   (clr_wr_i),
        .clr_data (clr_data_i),
        .flags    (flags_o),
        .en       (en_o),
        .pol      (pol_o),
        .irq      (irq_o)
    );

    assign wake_o = irq_o & lowpwr_i;

    // R2: request only while some enabled pin holds a flag
    a_r2_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((flags_o & en_o) != '0));
endmodule

// File: tb/test_pin_event_ctrl.sv
`timescale 1ns/1ps
module test_pin_event_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic         lowpwr = 1'b0;
    logic         en_wr = 1'b0, pol_wr = 1'b0, clr_wr = 1'b0;
    logic [N-1:0] en_data = '0, pol_data = '0, clr_data = '0;
    logic         irq, wake;
    logic [N-1:0] flags, en, pol;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    pin_event_ctrl #(.NPINS(N), .FILT_LEN(4), .SYNC_STAGES(2)) i_pin_event_ctrl (
        .clk (clk), .rst_n (rst_n), .pin_i (pin), .lowpwr_i (lowpwr),
        .en_wr_i (en_wr), .en_data_i (en_data),
        .pol_wr_i (pol_wr), .pol_data_i (pol_data),
        .clr_wr_i (clr_wr), .clr_data_i (clr_data),
        .irq_o (irq), .wake_o (wake), .flags_o (flags), .en_o (en), .pol_o (pol)
    );

    // {pin[2:0], dir, len[3:0] (0 = hold), pol_rise, en, exp_flag, exp_irq}
    localparam logic [11:0] VEC [10] = '{
        {3'd0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1},
        {3'd1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd2, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'd3, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd4, 1'b1, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd5, 1'b1, 4'd4, 1'b1, 1'b1, 1'b1, 1'b1},
        {3'd6, 1'b1, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd7, 1'b1, 4'd6, 1'b0, 1'b0, 1'b1, 1'b0},
        {3'd0, 1'b0, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd1, 1'b0, 4'd5, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); clr_wr = 1'b1; clr_data = '1;
        @(negedge clk); clr_wr = 1'b0; clr_data = '0;
    endtask

    task automatic set_masks(input logic [N-1:0] e, input logic [N-1:0] p);
        @(negedge clk); en_wr = 1'b1; en_data = e; pol_wr = 1'b1; pol_data = p;
        @(negedge clk); en_wr = 1'b0; pol_wr = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        // R1 / R10 reset state
        check("R1 reset flags", 32'(flags), 0);
        check("R1 reset en", 32'(en), 0);
        check("R1 reset pol", 32'(pol), 0);
        check("R1 reset irq", 32'(irq), 0);
        check("R10 reset wake", 32'(wake), 0);
        rst_n = 1'b1;
        wait_neg(3);

        for (int v = 0; v < 10; v++) begin
            logic [2:0] p;
            logic       dir, prise, pen, ef, ei;
            logic [3:0] len;
            {p, dir, len, prise, pen, ef, ei} = VEC[v];
            @(negedge clk); pin[p] = ~dir;
            wait_neg(12);
            clear_all();
            set_masks(N'(pen) << p, N'(prise) << p);
            wait_neg(2);
            // R9: polarity rewrite on stable pins leaves flags clear
            check($sformatf("R9 vec%0d no spurious flag", v), 32'(flags), 0);
            check($sformatf("R1 vec%0d pol readback", v), 32'(pol), 32'(N'(prise) << p));
            pin[p] = dir;
            if (len != 0) begin
                wait_neg(int'(len));
                pin[p] = ~dir;
            end
            wait_neg(14);
            // R3 R4 R5 R8: flag outcome per table
            check($sformatf("R4 R3 R5 R8 vec%0d flags", v), 32'(flags), 32'(N'(ef) << p));
            check($sformatf("R2 vec%0d irq", v), 32'(irq), 32'(ei));
        end

        // R7: clear lands in the same cycle as the set
        @(negedge clk); pin = '0;
        wait_neg(12);
        set_masks(8'h01, 8'h01);
        clear_all();
        @(negedge clk); pin[0] = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk); clr_wr = 1'b1; clr_data = 8'h01;
        @(negedge clk); clr_wr = 1'b0; clr_data = '0;
        check("R7 set wins over clear", 32'(flags), 32'h01);

        // R6: zeros do not clear, ones do
        @(negedge clk); clr_wr = 1'b1; clr_data = 8'h00;
        @(negedge clk); clr_wr = 1'b1; clr_data = 8'hFE;
        @(negedge clk); clr_wr = 1'b0; clr_data = '0;
        wait_neg(1);
        check("R6 write zero keeps flag", 32'(flags), 32'h01);

        // R10: wake follows irq only in low power
        check("R10 wake low outside low power", 32'(wake), 0);
        check("R2 irq with enabled flag", 32'(irq), 1);
        @(negedge clk); lowpwr = 1'b1;
        wait_neg(1);
        check("R10 wake in low power", 32'(wake), 1);
        @(negedge clk); clr_wr = 1'b1; clr_data = 8'h01;
        @(negedge clk); clr_wr = 1'b0; clr_data = '0;
        wait_neg(1);
        check("R6 write one clears flag", 32'(flags), 0);
        check("R10 wake drops with request", 32'(wake), 0);
        lowpwr = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule